// File: doc/BRIEF.md
# Binary to Residue Converter

This block converts an unsigned binary operand into its four residue digits for the moduli 8, 7, 5 and 3. No divider is used. The digit for modulus 8 is the low three bits of the operand, captured when the conversion starts. The other three digits are built up one operand bit per clock. For every bit that is set, each digit lane adds that bit's weight modulo its own modulus, using a modular adder. The weight for bit j is 2^j reduced by the lane's modulus. The lane computes these weights once, at elaboration, into a small per-lane table.

A caller presents an operand on `din` and pulses `start`. The block copies the operand into an internal shift register, so `din` may change freely afterwards. It then runs for `WIDTH` scan cycles and raises `done` for one cycle. The residue outputs stay valid and steady from that cycle until the next accepted start. A new start may be given in the same cycle as `done`, so conversions can run back to back.

The controller has three states. IDLE waits for `start`. SCAN examines one bit per cycle. FINISH drives `done`. Its transitions are: ACCEPT (IDLE to SCAN on `start`), STEP (SCAN to SCAN while bits remain), LAST (SCAN to FINISH once the top bit has been added), RELOAD (FINISH to SCAN on `start`) and RETIRE (FINISH to IDLE without `start`). The residue weights are periodic: 1,2,4 for modulus 7, 1,2,4,3 for modulus 5, and 1,2 for modulus 3. For example, operand 164 yields the digits 4, 3, 4 and 2.

Top module: `rns_fwd_conv`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all four residue outputs are 0.
- R2: At `done`, `res_m8` equals the operand modulo 8, which is bits [2:0] of the operand sampled with the accepted start.
- R3: At `done`, `res_m7` equals the accepted operand modulo 7.
- R4: At `done`, `res_m5` equals the accepted operand modulo 5.
- R5: At `done`, `res_m3` equals the accepted operand modulo 3.
- R6: `start` is accepted in IDLE and in the FINISH cycle. After the clock edge that accepts it, `busy` is 1 for exactly `WIDTH` cycles.
- R7: `done` is a single-cycle pulse. It rises on the `WIDTH+1`-th rising edge counted from the edge that accepted `start`, and `busy` is 0 while `done` is 1.
- R8: A `start` pulse while `busy` is 1 is ignored. The running conversion keeps its operand and its timing.
- R9: Changes on `din` after the accepting edge do not affect the result.
- R10: The residue outputs hold their values from `done` until the next accepted start, and each residue digit is always below its modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to convert `din` |
| din | input | WIDTH | Unsigned binary operand |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse; residues valid |
| res_m8 | output | 3 | Residue modulo 8 |
| res_m7 | output | 3 | Residue modulo 7 |
| res_m5 | output | 3 | Residue modulo 5 |
| res_m3 | output | 2 | Residue modulo 3 |

## Verification
The end of one conversion (the `done` pulse) and the start of the next (RELOAD) can occur in the same cycle. At that edge the accumulators are cleared while the finished digits are still being read. The bench provokes this by raising `start` with a fresh operand in the very cycle it observes `done`. It then requires two things. The digits sampled in that cycle must still belong to the first operand. The following conversion must deliver the second operand's digits after exactly `WIDTH+1` edges.

// File: rtl/rns_pkg.sv
package rns_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } conv_state_t;

    // Weight of bit position idx reduced by modulus m; loop bound is fixed
    function automatic int unsigned pow2_mod(input int unsigned idx,
                                             input int unsigned m);
        int unsigned r;
        r = 1 % m;
        for (int i = 0; i < 64; i++) begin
            if (i < idx) r = (r * 2) % m;
        end
        return r;
    endfunction

endpackage

// File: rtl/rns_mod_add.sv
module rns_mod_add #(
    parameter int unsigned MOD = 7,
    localparam int unsigned RW = $clog2(MOD)
) (
    input  logic [RW-1:0] a,
    input  logic [RW-1:0] b,
    output logic [RW-1:0] s
);
    logic [RW:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        if (raw >= (RW+1)'(MOD)) begin
            s = RW'(raw - (RW+1)'(MOD));
        end else begin
            s = raw[RW-1:0];
        end
    end
endmodule

// File: rtl/rns_lane.sv
module rns_lane #(
    parameter int unsigned MOD   = 7,
    parameter int unsigned WIDTH = 10,
    localparam int unsigned RW = $clog2(MOD),
    localparam int unsigned CW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          bit_in,
    input  logic [CW-1:0] bit_idx,
    output logic [RW-1:0] acc
);
    import rns_pkg::*;

    logic [RW-1:0] weight_tab [WIDTH];
    logic [RW-1:0] addend;
    logic [RW-1:0] sum;

    for (genvar j = 0; j < WIDTH; j++) begin : g_weight
        assign weight_tab[j] = RW'(pow2_mod(j, MOD));
    end

    always_comb begin
        addend = bit_in ? weight_tab[bit_idx] : '0;
    end

    rns_mod_add #(.MOD(MOD)) u_add (
        .a (acc),
        .b (addend),
        .s (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= sum;
        end
    end
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
    parameter int unsigned WIDTH = 10,
    localparam int unsigned CW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] din,
    output logic             busy,
    output logic             done,
    output logic [2:0]       res_m8,
    output logic [2:0]       res_m7,
    output logic [2:0]       res_m5,
    output logic [1:0]       res_m3
);
    import rns_pkg::*;

    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    conv_state_t     state_q, state_d;
    logic [WIDTH-1:0] shift_q;
    logic [CW-1:0]    idx_q;
    logic [2:0]       low_q;
    logic             accept;
    logic             step;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;                 // ACCEPT
            ST_SCAN:   if (idx_q == LAST_IDX) state_d = ST_FINISH;   // LAST / STEP
            ST_FINISH: state_d = start ? ST_SCAN : ST_IDLE;          // RELOAD / RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        accept = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = start;
            ST_SCAN:   begin busy = 1'b1; step = 1'b1; end
            ST_FINISH: begin done = 1'b1; accept = start; end
            default:   ;
        endcase
    end

    // Operand shift register, bit index and mod-8 digit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            low_q   <= '0;
        end else if (accept) begin
            shift_q <= din;
            idx_q   <= '0;
            low_q   <= din[2:0];
        end else if (step) begin
            shift_q <= shift_q >> 1;
            idx_q   <= idx_q + CW'(1);
        end
    end

    rns_lane #(.MOD(7), .WIDTH(WIDTH)) u_lane7 (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
        .bit_in(shift_q[0]), .bit_idx(idx_q), .acc(res_m7)
    );
    rns_lane #(.MOD(5), .WIDTH(WIDTH)) u_lane5 (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
        .bit_in(shift_q[0]), .bit_idx(idx_q), .acc(res_m5)
    );
    rns_lane #(.MOD(3), .WIDTH(WIDTH)) u_lane3 (
        .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
        .bit_in(shift_q[0]), .bit_idx(idx_q), .acc(res_m3)
    );

    assign res_m8 = low_q;
endmodule

// File: rtl/rns_fwd_conv_chk.sv
module rns_fwd_conv_chk #(
    parameter int unsigned WIDTH = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] res_m8,
    input logic [2:0] res_m7,
    input logic [2:0] res_m5,
    input logic [1:0] res_m3
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= run_len + 16'd1;
        else run_len <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R7
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> run_len == 16'(WIDTH)); // R6
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run_len < 16'(WIDTH)); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable({res_m8, res_m7, res_m5, res_m3})); // R10
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) res_m7 < 3'd7 && res_m5 < 3'd5 && res_m3 < 2'd3); // R10
endmodule

bind rns_fwd_conv rns_fwd_conv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .res_m8(res_m8), .res_m7(res_m7), .res_m5(res_m5), .res_m3(res_m3)
);

// File: tb/rns_fwd_conv_tb.sv
module rns_fwd_conv_tb_top;
    localparam int unsigned WIDTH = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic             busy, done;
    logic [2:0]       res_m8, res_m7, res_m5;
    logic [1:0]       res_m3;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rns_fwd_conv #(.WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .busy(busy), .done(done),
        .res_m8(res_m8), .res_m7(res_m7), .res_m5(res_m5), .res_m3(res_m3)
    );

    function automatic int unsigned ref_mod(input int unsigned v, input int unsigned m);
        return v % m;
    endfunction

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present operand with start; return at the negedge after the accepting edge
    task automatic launch(input int unsigned v);
        din   = WIDTH'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done, optionally disturbing din and start; check the digits
    task automatic finish(input int unsigned v, input bit disturb);
        int n;
        n = 1;
        chk("R6 busy after accept", busy, 1);
        while (!done && n < 100) begin
            if (disturb) begin
                din   = WIDTH'($urandom);
                start = (n == 3);
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk("R7 latency", n, WIDTH + 1);
        chk("R7 busy low at done", busy, 0);
        chk("R2 mod8", res_m8, ref_mod(v, 8));
        chk("R3 mod7", res_m7, ref_mod(v, 7));
        chk("R4 mod5", res_m5, ref_mod(v, 5));
        chk("R5 mod3", res_m3, ref_mod(v, 3));
    endtask

    task automatic hold_check(input int unsigned v);
        din = WIDTH'($urandom);
        @(negedge clk);
        chk("R7 done single pulse", done, 0);
        chk("R10 hold mod8", res_m8, ref_mod(v, 8));
        chk("R10 hold mod7", res_m7, ref_mod(v, 7));
        chk("R10 hold mod5", res_m5, ref_mod(v, 5));
        chk("R10 hold mod3", res_m3, ref_mod(v, 3));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 digits", {res_m8, res_m7, res_m5, res_m3}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners: worked example, zero, all ones
        launch(164); finish(164, 0); hold_check(164);
        launch(0);   finish(0, 0);   hold_check(0);
        launch(1023); finish(1023, 0); hold_check(1023);

        // Exhaustive sweep of every operand
        for (int v = 0; v < (1 << WIDTH); v++) begin
            launch(v);
            finish(v, 0);
            @(negedge clk);
        end

        // Random with din churn and start pulses while busy (R8, R9)
        for (int k = 0; k < 200; k++) begin
            int unsigned v;
            v = $urandom % (1 << WIDTH);
            launch(v);
            finish(v, 1);
            hold_check(v);
        end

        // Back-to-back: start in the done cycle (RELOAD)
        for (int k = 0; k < 50; k++) begin
            int unsigned a, b;
            a = $urandom % (1 << WIDTH);
            b = $urandom % (1 << WIDTH);
            launch(a);
            finish(a, 0);
            launch(b);
            finish(b, 0);
            hold_check(b);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule